// File: doc/BRIEF.md
# Bus-Master Block Transfer Engine

This engine moves a block of 16-bit words across an asynchronous bus as bus master once mastership has been won elsewhere. The host gives a cycle type, a start address and a word count, then pulses start. For each word the engine drives the address and the control code, and for writes it also drives data read from a local word buffer. It holds these lines for a programmable setup time and then raises master sync. When the slave answers with slave sync, the engine drops master sync, waits for slave sync to fall and moves on to the next word. Each word steps the address by two.

When the block ends, a completion event is raised and stays up until the host acknowledges it. On success the status reads idle and the current address shows the last word accessed. If a slave does not answer within a bounded number of cycles, the status reads timeout and the current address shows the word that failed. If bus init is sensed during a transfer, the engine stops at once and flags the abort separately.

Top module: `dma_block_engine`

## Requirements
- R1: A start pulse is accepted only when the cycle code is 00 (word read) or 10 (word write), the word count is 1 to MAX_WORDS (512 by default) and bus init is low. An accepted start shows status 1 (running) in the cycle after the start edge. Codes 01 (read-pause) and 11 (byte write), a count of 0 and a count above MAX_WORDS are ignored: the status stays 0, master sync stays low and no event is raised.
- R2: Word k of a block uses bus address start+2k and buffer index k. While running, the address only ever changes by +2.
- R3: Master sync rises SETUP_CYC cycles after the address, the control code and (for writes) the data were set up. For the first word, it is seen high in the (SETUP_CYC+1)-th sampled cycle after the start edge. Address and control code stay stable while master sync is high.
- R4: Master sync is high only while running. It is held until slave sync arrives. The next word starts only after slave sync has fallen again.
- R5: In a read block, the bus data present while slave sync is high are written to the buffer at the word's index.
- R6: In a write block, the data bus is driven from the buffer at the word's index. The data enable is high only while running a write.
- R7: On normal completion the status is 0, the init-abort flag is 0 and the current address equals start+2(count-1).
- R8: If slave sync does not arrive within TMO_CYC cycles of master sync, the block is stopped. Master sync is high for exactly TMO_CYC cycles on that word, the status becomes 2 (timeout) and the current address holds the failed address. Words before it have been transferred.
- R9: Bus init sensed while running stops the block on the next edge. Master sync goes low, the status returns to 0, the init-abort flag is set and the event is raised. The next accepted start clears the flag.
- R10: The completion event, raised at the end of every block (success, timeout or abort), stays set until event_ack is pulsed. It clears in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse for a block |
| cyc_type | input | 2 | Cycle code: 00 read, 10 write (others rejected) |
| start_addr | input | ADDR_W | Address of the first word |
| word_count | input | CNT_W | Number of words, 1..MAX_WORDS |
| event_ack | input | 1 | Host acknowledge of the completion event |
| status | output | 2 | 0 idle, 1 running, 2 timeout |
| cur_addr | output | ADDR_W | Current, last, or failed address |
| done_evt | output | 1 | Completion event, held until acknowledged |
| init_abort | output | 1 | Last block was stopped by bus init |
| buf_idx | output | IDX_W | Buffer word index |
| buf_rdata | input | DATA_W | Buffer word at buf_idx (combinational read) |
| buf_we | output | 1 | Buffer write strobe for read blocks |
| buf_wdata | output | DATA_W | Word to write into the buffer |
| bus_addr | output | ADDR_W | Bus address |
| bus_ctrl | output | 2 | Bus cycle code |
| bus_data_out | output | DATA_W | Write data to the bus |
| bus_data_oe | output | 1 | Write data enable |
| bus_data_in | input | DATA_W | Read data from the bus |
| msyn | output | 1 | Master sync |
| ssyn | input | 1 | Slave sync |
| bus_init | input | 1 | Bus init sensed |

## Verification
Two situations are hardest to reach from the ports. The first is a timeout in the middle of a block, after some words have already completed. The bench slave never answers at any address with bit 17 set. A write block that starts just below that boundary therefore moves two words and then stalls on the third. The second is an init abort while a word handshake is pending. Bus init is raised during a long read against a slow slave, and then a new start must clear the abort flag.

// File: rtl/dma_eng_pkg.sv
// Shared types and codes for the block transfer engine.
package dma_eng_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_SETUP   = 2'd1,
        SEQ_SYNC    = 2'd2,
        SEQ_RELEASE = 2'd3
    } seq_state_t;

    localparam logic [1:0] CYC_RD_WORD  = 2'b00;
    localparam logic [1:0] CYC_RD_PAUSE = 2'b01;
    localparam logic [1:0] CYC_WR_WORD  = 2'b10;
    localparam logic [1:0] CYC_WR_BYTE  = 2'b11;

    localparam logic [1:0] STAT_IDLE = 2'd0;
    localparam logic [1:0] STAT_RUN  = 2'd1;
    localparam logic [1:0] STAT_TMO  = 2'd2;
endpackage

// File: rtl/dma_step_timer.sv
// Cycle counter shared by the setup wait and the slave-sync timeout.
// Assumes the sequencer clears it on every state change.
module dma_step_timer #(
    parameter int SETUP_CYC = 3,
    parameter int TMO_CYC   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic setup_last,
    output logic tmo_last
);
    localparam int MAXV = (SETUP_CYC > TMO_CYC) ? SETUP_CYC : TMO_CYC;
    localparam int CW   = $clog2(MAXV + 1);

    logic [CW-1:0] cnt;

    // count cycles spent in the current step, saturating at the largest limit
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (cnt != CW'(MAXV))
            cnt <= cnt + CW'(1);
    end

    assign setup_last = (cnt == CW'(SETUP_CYC - 1));
    assign tmo_last   = (cnt == CW'(TMO_CYC - 1));
endmodule

// File: rtl/dma_addr_track.sv
// Holds the block parameters: current address, words left, buffer index, cycle code.
// Assumes load and step are never asserted together.
module dma_addr_track #(
    parameter int ADDR_W = 18,
    parameter int CNT_W  = 10,
    parameter int IDX_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [CNT_W-1:0]  ld_count,
    input  logic [1:0]        ld_cyc,
    output logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [1:0]        cyc,
    output logic              last_word
);
    logic [CNT_W-1:0] left;

    // load a new block, or advance to the next word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            idx  <= '0;
            cyc  <= 2'b00;
            left <= '0;
        end else if (load) begin
            addr <= ld_addr;
            idx  <= '0;
            cyc  <= ld_cyc;
            left <= ld_count;
        end else if (step) begin
            addr <= addr + ADDR_W'(2);
            idx  <= idx + IDX_W'(1);
            left <= left - CNT_W'(1);
        end
    end

    assign last_word = (left == CNT_W'(1));
endmodule

// File: rtl/dma_seq_fsm.sv
// Word sequencer: setup, master sync, release; tracks the end-of-block flags.
// Assumes start_ok is already qualified for cycle code, count and init.
module dma_seq_fsm
    import dma_eng_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_ok,
    input  logic       event_ack,
    input  logic       bus_init,
    input  logic       ssyn,
    input  logic       setup_last,
    input  logic       tmo_last,
    input  logic       last_word,
    input  logic       is_write,
    output seq_state_t st,
    output logic       load,
    output logic       step,
    output logic       tmr_clr,
    output logic       cap_we,
    output logic [1:0] status,
    output logic       evt,
    output logic       aborted
);
    seq_state_t nxt;
    logic       err_q;
    logic       fin_ok, fin_tmo, fin_abort;

    // next-state and strobe decode for the current word
    always_comb begin
        nxt       = st;
        load      = 1'b0;
        step      = 1'b0;
        cap_we    = 1'b0;
        fin_ok    = 1'b0;
        fin_tmo   = 1'b0;
        fin_abort = 1'b0;
        case (st)
            SEQ_IDLE: begin
                if (start_ok) begin
                    load = 1'b1;
                    nxt  = SEQ_SETUP;
                end
            end
            SEQ_SETUP: begin
                if (setup_last) nxt = SEQ_SYNC;
            end
            SEQ_SYNC: begin
                if (ssyn) begin
                    cap_we = !is_write;
                    nxt    = SEQ_RELEASE;
                end else if (tmo_last) begin
                    fin_tmo = 1'b1;
                    nxt     = SEQ_IDLE;
                end
            end
            SEQ_RELEASE: begin
                if (!ssyn) begin
                    if (last_word) begin
                        fin_ok = 1'b1;
                        nxt    = SEQ_IDLE;
                    end else begin
                        step = 1'b1;
                        nxt  = SEQ_SETUP;
                    end
                end
            end
            default: nxt = SEQ_IDLE;
        endcase
        if (st != SEQ_IDLE && bus_init) begin
            nxt       = SEQ_IDLE;
            step      = 1'b0;
            cap_we    = 1'b0;
            fin_ok    = 1'b0;
            fin_tmo   = 1'b0;
            fin_abort = 1'b1;
        end
    end

    assign tmr_clr = (nxt != st) || (st == SEQ_IDLE) || (st == SEQ_RELEASE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SEQ_IDLE;
        else        st <= nxt;
    end

    // end-of-block flags: timeout, init abort and the held completion event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            aborted <= 1'b0;
            evt     <= 1'b0;
        end else begin
            if (load) begin
                err_q   <= 1'b0;
                aborted <= 1'b0;
            end
            if (fin_tmo)   err_q   <= 1'b1;
            if (fin_abort) aborted <= 1'b1;
            if (fin_ok || fin_tmo || fin_abort) evt <= 1'b1;
            else if (event_ack)                 evt <= 1'b0;
        end
    end

    assign status = (st != SEQ_IDLE) ? STAT_RUN : (err_q ? STAT_TMO : STAT_IDLE);
endmodule

// File: rtl/dma_block_engine.sv
// Bus-master block transfer engine top: qualifies the start request and
// ties the sequencer, timer and address tracker to the bus and buffer ports.
// Assumes bus mastership is already held and the buffer read is combinational.
module dma_block_engine
    import dma_eng_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int MAX_WORDS = 512,
    parameter int SETUP_CYC = 3,
    parameter int TMO_CYC   = 16,
    localparam int CNT_W    = $clog2(MAX_WORDS + 1),
    localparam int IDX_W    = $clog2(MAX_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        cyc_type,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  word_count,
    input  logic              event_ack,
    output logic [1:0]        status,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              done_evt,
    output logic              init_abort,
    output logic [IDX_W-1:0]  buf_idx,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic              buf_we,
    output logic [DATA_W-1:0] buf_wdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_ctrl,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic              msyn,
    input  logic              ssyn,
    input  logic              bus_init
);
    seq_state_t        st;
    logic              load, step, tmr_clr;
    logic              setup_last, tmo_last, last_word;
    logic              start_ok, cyc_ok, cnt_ok;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        cyc;

    // only plain word read and word write run as blocks
    always_comb begin
        cyc_ok   = (cyc_type == CYC_RD_WORD) || (cyc_type == CYC_WR_WORD);
        cnt_ok   = (word_count != '0) && (word_count <= CNT_W'(MAX_WORDS));
        start_ok = start && cyc_ok && cnt_ok && !bus_init;
    end

    dma_seq_fsm u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ok   (start_ok),
        .event_ack  (event_ack),
        .bus_init   (bus_init),
        .ssyn       (ssyn),
        .setup_last (setup_last),
        .tmo_last   (tmo_last),
        .last_word  (last_word),
        .is_write   (cyc[1]),
        .st         (st),
        .load       (load),
        .step       (step),
        .tmr_clr    (tmr_clr),
        .cap_we     (buf_we),
        .status     (status),
        .evt        (done_evt),
        .aborted    (init_abort)
    );

    dma_step_timer #(
        .SETUP_CYC (SETUP_CYC),
        .TMO_CYC   (TMO_CYC)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (tmr_clr),
        .setup_last (setup_last),
        .tmo_last   (tmo_last)
    );

    dma_addr_track #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .IDX_W  (IDX_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .ld_addr   (start_addr),
        .ld_count  (word_count),
        .ld_cyc    (cyc_type),
        .addr      (addr),
        .idx       (buf_idx),
        .cyc       (cyc),
        .last_word (last_word)
    );

    assign cur_addr     = addr;
    assign bus_addr     = addr;
    assign bus_ctrl     = cyc;
    assign msyn         = (st == SEQ_SYNC);
    assign bus_data_oe  = (st != SEQ_IDLE) && cyc[1];
    assign bus_data_out = buf_rdata;
    assign buf_wdata    = bus_data_in;
endmodule

// File: rtl/dma_block_engine_chk.sv
// Protocol checker for the block transfer engine, bound to its top.
module dma_block_engine_chk #(
    parameter int ADDR_W  = 18,
    parameter int TMO_CYC = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              event_ack,
    input logic [1:0]        status,
    input logic              done_evt,
    input logic              init_abort,
    input logic              buf_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_ctrl,
    input logic              bus_data_oe,
    input logic              msyn,
    input logic              ssyn,
    input logic              bus_init
);
    localparam int HW = $clog2(TMO_CYC + 2);
    logic [HW-1:0] hang_cnt;

    // cycles master sync has waited without slave sync
    always_ff @(posedge clk) begin
        if (!rst_n)              hang_cnt <= '0;
        else if (msyn && !ssyn)  hang_cnt <= hang_cnt + HW'(1);
        else                     hang_cnt <= '0;
    end

    assert_ctrl_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status == 2'd1 |-> (bus_ctrl == 2'b00 || bus_ctrl == 2'b10));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd1 && $past(status) == 2'd1 && !$stable(bus_addr))
        |-> bus_addr == $past(bus_addr) + ADDR_W'(2));

    assert_setup_before_msyn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msyn) |-> $stable(bus_addr) && $stable(bus_ctrl));

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (msyn && $past(msyn)) |-> $stable(bus_addr) && $stable(bus_ctrl));

    assert_msyn_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'd1 |-> !msyn);

    assert_capture_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (!bus_ctrl[1] && msyn && ssyn));

    assert_oe_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> (bus_ctrl[1] && status == 2'd1));

    assert_tmo_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hang_cnt <= HW'(TMO_CYC));

    assert_init_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_init && status == 2'd1) |=> (status != 2'd1 && !msyn && init_abort && done_evt));

    assert_evt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && !event_ack) |=> done_evt);
endmodule

bind dma_block_engine dma_block_engine_chk #(
    .ADDR_W  (ADDR_W),
    .TMO_CYC (TMO_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .event_ack   (event_ack),
    .status      (status),
    .done_evt    (done_evt),
    .init_abort  (init_abort),
    .buf_we      (buf_we),
    .bus_addr    (bus_addr),
    .bus_ctrl    (bus_ctrl),
    .bus_data_oe (bus_data_oe),
    .msyn        (msyn),
    .ssyn        (ssyn),
    .bus_init    (bus_init)
);

// File: tb/dma_block_engine_bench.sv
`timescale 1ns/1ps
module dma_block_engine_bench;
    localparam int ADDR_W = 18;
    localparam int DATA_W = 16;
    localparam int MAXW   = 512;
    localparam int SETUP  = 2;
    localparam int TMO    = 12;
    localparam int CNT_W  = 10;
    localparam int IDX_W  = 9;

    // vector: {cyc[2], addr[18], count[10], slave delay[4]}
    localparam int NV = 7;
    localparam logic [33:0] VEC [NV] = '{
        {2'b10, 18'h00100, 10'd4,   4'd0},
        {2'b00, 18'h00100, 10'd4,   4'd2},
        {2'b10, 18'h001F8, 10'd8,   4'd1},
        {2'b00, 18'h00000, 10'd1,   4'd3},
        {2'b10, 18'h00040, 10'd32,  4'd0},
        {2'b00, 18'h00080, 10'd512, 4'd0},
        {2'b10, 18'h01000, 10'd512, 4'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] cyc_type = 2'b00;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [CNT_W-1:0] word_count = '0;
    logic event_ack = 1'b0;
    logic bus_init = 1'b0;
    logic ssyn = 1'b0;
    logic [1:0] status;
    logic [ADDR_W-1:0] cur_addr, bus_addr;
    logic done_evt, init_abort, buf_we, bus_data_oe, msyn;
    logic [IDX_W-1:0] buf_idx;
    logic [DATA_W-1:0] buf_rdata, buf_wdata, bus_data_out, bus_data_in;
    logic [1:2] bus_ctrl_dummy;
    logic [1:0] bus_ctrl;

    logic [15:0] bbuf [512];
    logic [15:0] mem  [256];
    logic        init_req = 1'b0;
    logic [7:0]  seed = 8'd0;
    logic [3:0]  slave_delay = 4'd0;
    logic [3:0]  dcnt = 4'd0;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    dma_block_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_WORDS(MAXW),
        .SETUP_CYC(SETUP), .TMO_CYC(TMO)
    ) u_dma_block_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .cyc_type(cyc_type),
        .start_addr(start_addr), .word_count(word_count), .event_ack(event_ack),
        .status(status), .cur_addr(cur_addr), .done_evt(done_evt),
        .init_abort(init_abort), .buf_idx(buf_idx), .buf_rdata(buf_rdata),
        .buf_we(buf_we), .buf_wdata(buf_wdata), .bus_addr(bus_addr),
        .bus_ctrl(bus_ctrl), .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
        .bus_data_in(bus_data_in), .msyn(msyn), .ssyn(ssyn), .bus_init(bus_init)
    );

    assign bus_ctrl_dummy = bus_ctrl;

    function automatic logic [15:0] bpat(input logic [7:0] s, input int i);
        return 16'hA000 + 16'(i * 3) + 16'(s) * 16'h0101;
    endfunction
    function automatic logic [15:0] mpat(input logic [7:0] s, input int i);
        return 16'h5000 + 16'(i * 7) + 16'(s) * 16'h0011;
    endfunction

    assign buf_rdata   = bbuf[buf_idx];
    assign bus_data_in = mem[bus_addr[8:1]];

    // buffer capture, slave memory write and pattern preload
    always @(posedge clk) begin
        if (init_req) begin
            for (int i = 0; i < 512; i++) bbuf[i] <= bpat(seed, i);
            for (int i = 0; i < 256; i++) mem[i] <= mpat(seed, i);
        end else begin
            if (buf_we) bbuf[buf_idx] <= buf_wdata;
            if (msyn && ssyn && bus_ctrl == 2'b10 && bus_data_oe)
                mem[bus_addr[8:1]] <= bus_data_out;
        end
    end

    // slave sync model; addresses with bit 17 set never answer
    always @(negedge clk) begin
        if (!msyn) begin
            ssyn <= 1'b0;
            dcnt <= 4'd0;
        end else if (!ssyn && !bus_addr[17]) begin
            if (dcnt >= slave_delay) ssyn <= 1'b1;
            else dcnt <= dcnt + 4'd1;
        end
    end

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic preload(input logic [7:0] s);
        @(negedge clk);
        seed = s;
        init_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
    endtask

    task automatic kick(input logic [1:0] c, input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] n);
        @(negedge clk);
        cyc_type = c; start_addr = a; word_count = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_evt(output int ok);
        int lim = 0;
        while (!done_evt && lim < 20000) begin
            @(negedge clk);
            lim++;
        end
        ok = done_evt ? 1 : 0;
    endtask

    task automatic ack();
        @(negedge clk);
        event_ack = 1'b1;
        @(negedge clk);
        event_ack = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int ok, n, bad, lo;
        logic [1:0] c;
        logic [ADDR_W-1:0] a;
        logic [CNT_W-1:0] cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(status == 2'd0 && !msyn && !done_evt && !init_abort && !bus_data_oe,
              "reset state R4 R10", {status, msyn, done_evt, init_abort}, 0);

        // rejected starts: R1
        for (int k = 0; k < 4; k++) begin
            c = (k == 0) ? 2'b01 : (k == 1) ? 2'b11 : 2'b00;
            cnt = (k == 2) ? 10'd0 : (k == 3) ? 10'd513 : 10'd4;
            kick(c, 18'h00100, cnt);
            repeat (6) @(negedge clk);
            check(status == 2'd0 && !msyn && !done_evt, "R1 rejected start",
                  {status, msyn, done_evt}, 0);
        end

        // table walk: R2 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            c = VEC[v][33:32]; a = VEC[v][31:14]; cnt = VEC[v][13:4];
            preload(8'(v + 1));
            slave_delay = VEC[v][3:0];
            kick(c, a, cnt);
            check(status == 2'd1, "R1 accepted start", status, 1);
            n = 1;
            while (!msyn && n < 50) begin @(negedge clk); n++; end
            if (v == 0) check(n == SETUP + 1, "R3 setup before msyn", n, SETUP + 1);
            wait_evt(ok);
            check(ok == 1 && status == 2'd0 && !init_abort, "R7 completion status",
                  {status, init_abort}, 0);
            check(cur_addr == a + ADDR_W'(2 * (int'(cnt) - 1)), "R7 R2 last address",
                  cur_addr, a + ADDR_W'(2 * (int'(cnt) - 1)));
            bad = 0;
            lo = (cnt > 256) ? int'(cnt) - 256 : 0;
            for (int k = 0; k < int'(cnt); k++) begin
                if (c == 2'b00) begin
                    if (bbuf[k] != mpat(8'(v + 1), (int'(a[8:1]) + k) % 256)) bad++;
                end else if (k >= lo) begin
                    if (mem[(int'(a[8:1]) + k) % 256] != bpat(8'(v + 1), k)) bad++;
                end
            end
            check(bad == 0, (c == 2'b00) ? "R5 R2 read data" : "R6 R2 write data", bad, 0);
            ack();
        end

        // event hold until acknowledge: R10
        preload(8'h20);
        slave_delay = 4'd0;
        kick(2'b00, 18'h00010, 10'd2);
        wait_evt(ok);
        repeat (10) @(negedge clk);
        check(done_evt == 1'b1, "R10 event held", done_evt, 1);
        ack();
        check(done_evt == 1'b0, "R10 event cleared by ack", done_evt, 0);

        // mid-block timeout: R8
        preload(8'h30);
        slave_delay = 4'd1;
        kick(2'b10, 18'h1FFFC, 10'd4);
        n = 0;
        ok = 0;
        for (int t = 0; t < 2000 && !done_evt; t++) begin
            if (msyn && bus_addr == 18'h20000) n++;
            @(negedge clk);
        end
        check(done_evt && status == 2'd2, "R8 timeout status", status, 2);
        check(cur_addr == 18'h20000, "R8 failed address", cur_addr, 18'h20000);
        check(n == TMO, "R8 msyn window", n, TMO);
        check(mem[8'hFE] == bpat(8'h30, 0) && mem[8'hFF] == bpat(8'h30, 1),
              "R8 earlier words written", mem[8'hFE], bpat(8'h30, 0));
        check(!msyn && !bus_data_oe, "R4 R6 bus released after timeout",
              {msyn, bus_data_oe}, 0);
        ack();

        // init abort: R9
        preload(8'h40);
        slave_delay = 4'd4;
        kick(2'b00, 18'h00200, 10'd100);
        repeat (20) @(negedge clk);
        bus_init = 1'b1;
        @(negedge clk);
        check(done_evt && init_abort && status == 2'd0 && !msyn, "R9 init stop",
              {done_evt, init_abort, status, msyn}, 6'b110000);
        bus_init = 1'b0;
        ack();
        kick(2'b00, 18'h00200, 10'd1);
        check(status == 2'd1 && !init_abort, "R9 restart clears abort",
              {status, init_abort}, 2);
        wait_evt(ok);
        check(ok == 1 && status == 2'd0 && cur_addr == 18'h00200, "R7 single word", cur_addr, 18'h00200);
        ack();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule